// File: doc/BRIEF.md
# Six-Stage Fragment Colour Combiner with Carry Buffer

The block takes one fragment at a time and runs it through six colour-combiner stages, from stage 0 to stage 5, one stage per clock. Each fragment brings a primary colour and three texture colours, all RGBA with 8 bits per channel. Every stage picks two operands from a fixed set of sources and applies one of a few per-channel operations. The output of stage 5 is the pixel result. A carry buffer sits beside the chain. It is loaded from a register when a fragment is accepted. Stages 0 to 3 can overwrite its RGB part and its alpha part under two separate masks, so a later stage can read back a result from an earlier stage after other stages have run in between.

The controller has three states. **S_IDLE** holds `frag_ready` high and takes register writes. The transition *accept* (`frag_valid` while in S_IDLE) latches the colours, loads the carry buffer and enters **S_RUN**. In S_RUN the transition *step* evaluates one stage per clock. The transition *finish* leaves S_RUN after stage 5 and enters **S_DONE**, which raises `pix_done` for one cycle. The transition *release* then returns to S_IDLE.

All colours are packed in the same way: R in bits 7:0, G in 15:8, B in 23:16 and A in 31:24.

Top module: `frag_combiner`

## Requirements
- R1: After reset, `frag_ready` is 1, `pix_done` is 0 and `pix_rgba` is 0. Every configuration register is cleared, so each stage replaces its output with the primary colour and the buffer colour is 0.
- R2: A fragment is accepted on a rising edge where `frag_valid` and `frag_ready` are both 1. `frag_ready` stays 0 until `pix_done` has been shown. `pix_done` is a one-cycle pulse that begins on the sixth rising edge after the accepting edge, and `pix_rgba` holds the stage 5 result from then on.
- R3: Source codes: 0x0 selects the primary colour, 0x4, 0x5 and 0x6 select textures 1, 2 and 3, 0xD selects the carry buffer, 0xE selects the stage constant and 0xF selects the previous stage's output. Any other code selects zero.
- R4: Operation code 0 passes operand A. Code 1 gives (A*B+127)/255 per channel, rounded down. Code 2 gives A+B per channel, saturating at 255. Code 3 behaves as code 0.
- R5: For stage 0, source 0xF returns the primary colour.
- R6: When a fragment is accepted, the carry buffer is loaded from the buffer-colour register. That register uses the channel layout above.
- R7: In the buffer-update word, bits 11:8 are the RGB masks and bits 15:12 are the alpha masks, with bit n of each belonging to stage n. Each mask bit copies only its own part of the stage output into the carry buffer.
- R8: Stages 4 and 5 never change the carry buffer.
- R9: A stage that reads the carry buffer sees the value left by the earlier stages, not its own result.
- R10: Register writes made while a fragment is in flight (S_RUN or S_DONE) are ignored.
- R11: The stage configuration words are at word addresses 0xC0, 0xC8, 0xD0, 0xD8, 0xF0 and 0xF8, for stages 0 to 5. Each word holds source A in bits 3:0, source B in bits 7:4 and the operation in bits 9:8. Each stage's constant colour is at its base address + 1. The buffer-update word is at 0xE0 and the buffer colour is at 0xFD.
- R12: A reset during a fragment drops that fragment: no `pix_done` follows, and the block returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frag_valid | input | 1 | A fragment is offered |
| frag_ready | output | 1 | Block is idle and can accept a fragment |
| prim_rgba | input | 32 | Primary colour |
| tex1_rgba | input | 32 | Texture colour 1 |
| tex2_rgba | input | 32 | Texture colour 2 |
| tex3_rgba | input | 32 | Texture colour 3 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| pix_rgba | output | 32 | Result of the last stage |
| pix_done | output | 1 | One-cycle pulse when `pix_rgba` is updated |

## Verification
The assertions assume that `frag_valid` is only acted on in S_IDLE. They also assume that the configuration seen by a running fragment can change only through `cfg_we`, which the block gates off outside S_IDLE. The stimulus drives inputs on the falling edge. It offers a new fragment only after the previous `pix_done`, and makes its mid-fragment register writes and its mid-fragment reset on purpose, so that the gating and the dropping of the fragment are exercised rather than avoided.

// File: rtl/fcomb_pkg.sv
package fcomb_pkg;

    localparam int SRC_W = 4;

    localparam logic [SRC_W-1:0] SRC_PRIMARY = 4'h0;
    localparam logic [SRC_W-1:0] SRC_TEX1    = 4'h4;
    localparam logic [SRC_W-1:0] SRC_TEX2    = 4'h5;
    localparam logic [SRC_W-1:0] SRC_TEX3    = 4'h6;
    localparam logic [SRC_W-1:0] SRC_CARRY   = 4'hD;
    localparam logic [SRC_W-1:0] SRC_CONST   = 4'hE;
    localparam logic [SRC_W-1:0] SRC_PREV    = 4'hF;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_MUL  = 2'd1,
        OP_ADDS = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    // per-stage word: source A in 3:0, source B in 7:4, operation in 9:8
    typedef struct packed {
        op_e              op;
        logic [SRC_W-1:0] src_b;
        logic [SRC_W-1:0] src_a;
    } stage_cfg_t;

    localparam int          MASK_RGB_LSB = 8;
    localparam int          MASK_A_LSB   = 12;
    localparam int unsigned CTRL_ADDR    = 32'hE0;
    localparam int unsigned BUFCOL_ADDR  = 32'hFD;

    // stages 0..3 sit at 0xC0 + 8*i; stages from 4 on continue at 0xF0
    function automatic int unsigned stage_base(input int unsigned idx);
        return (idx < 4) ? (32'hC0 + 8 * idx) : (32'hF0 + 8 * (idx - 4));
    endfunction

endpackage

// File: rtl/fcomb_cfg_regs.sv
module fcomb_cfg_regs
    import fcomb_pkg::*;
#(
    parameter int STAGES       = 6,
    parameter int CARRY_STAGES = 4,
    parameter int ADDR_W       = 10,
    parameter int RGBA_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output stage_cfg_t        stage_cfg   [STAGES],
    output logic [RGBA_W-1:0] stage_const [STAGES],
    output logic [CARRY_STAGES-1:0] mask_rgb,
    output logic [CARRY_STAGES-1:0] mask_a,
    output logic [RGBA_W-1:0] buf_color
);

    localparam int                CFG_W  = $bits(stage_cfg_t);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(BUFCOL_ADDR);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(stage_base(s));
        localparam logic [ADDR_W-1:0] A_K   = ADDR_W'(stage_base(s) + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_cfg[s]   <= '0;
                stage_const[s] <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_CFG) stage_cfg[s]   <= stage_cfg_t'(wr_data[CFG_W-1:0]);
                if (wr_addr == A_K)   stage_const[s] <= wr_data[RGBA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_rgb  <= '0;
            mask_a    <= '0;
            buf_color <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                mask_rgb <= wr_data[MASK_RGB_LSB +: CARRY_STAGES];
                mask_a   <= wr_data[MASK_A_LSB +: CARRY_STAGES];
            end
            if (wr_addr == A_BUF) buf_color <= wr_data[RGBA_W-1:0];
        end
    end

endmodule

// File: rtl/fcomb_stage_alu.sv
module fcomb_stage_alu
    import fcomb_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  stage_cfg_t         cfg,
    input  logic               first_stage,
    input  logic [4*CH_W-1:0]  prim,
    input  logic [4*CH_W-1:0]  tex1,
    input  logic [4*CH_W-1:0]  tex2,
    input  logic [4*CH_W-1:0]  tex3,
    input  logic [4*CH_W-1:0]  konst,
    input  logic [4*CH_W-1:0]  prev,
    input  logic [4*CH_W-1:0]  carry,
    output logic [4*CH_W-1:0]  result
);

    localparam int RGBA_W = 4 * CH_W;
    localparam int PROD_W = 2 * CH_W + 1;
    localparam int MAXV   = (1 << CH_W) - 1;
    localparam int HALF   = MAXV / 2;

    function automatic logic [RGBA_W-1:0] pick(input logic [SRC_W-1:0] code,
        input logic [RGBA_W-1:0] p, t1, t2, t3, k, pv, cb, input logic first);
        case (code)
            SRC_PRIMARY: return p;
            SRC_TEX1:    return t1;
            SRC_TEX2:    return t2;
            SRC_TEX3:    return t3;
            SRC_CARRY:   return cb;
            SRC_CONST:   return k;
            SRC_PREV:    return first ? p : pv;
            default:     return '0;
        endcase
    endfunction

    logic [RGBA_W-1:0] opa, opb;
    assign opa = pick(cfg.src_a, prim, tex1, tex2, tex3, konst, prev, carry, first_stage);
    assign opb = pick(cfg.src_b, prim, tex1, tex2, tex3, konst, prev, carry, first_stage);

    for (genvar c = 0; c < 4; c++) begin : g_ch
        logic [CH_W-1:0] a, b, scaled;
        logic [CH_W:0]   sum;
        assign a      = opa[c*CH_W +: CH_W];
        assign b      = opb[c*CH_W +: CH_W];
        assign sum    = {1'b0, a} + {1'b0, b};
        assign scaled = CH_W'(({{(CH_W+1){1'b0}}, a} * {{(CH_W+1){1'b0}}, b}
                               + PROD_W'(HALF)) / PROD_W'(MAXV));

        always_comb begin
            unique case (cfg.op)
                OP_MUL:  result[c*CH_W +: CH_W] = scaled;
                OP_ADDS: result[c*CH_W +: CH_W] = sum[CH_W] ? CH_W'(MAXV) : sum[CH_W-1:0];
                OP_PASS,
                OP_RSVD: result[c*CH_W +: CH_W] = a;
                default: result[c*CH_W +: CH_W] = a;
            endcase
        end
    end

endmodule

// File: rtl/frag_combiner.sv
module frag_combiner
    import fcomb_pkg::*;
#(
    parameter int STAGES       = 6,
    parameter int CARRY_STAGES = 4,
    parameter int CH_W         = 8,
    parameter int ADDR_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frag_valid,
    output logic              frag_ready,
    input  logic [4*CH_W-1:0] prim_rgba,
    input  logic [4*CH_W-1:0] tex1_rgba,
    input  logic [4*CH_W-1:0] tex2_rgba,
    input  logic [4*CH_W-1:0] tex3_rgba,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [4*CH_W-1:0] pix_rgba,
    output logic              pix_done
);

    localparam int RGBA_W = 4 * CH_W;
    localparam int RGB_W  = 3 * CH_W;
    localparam int IDX_W  = $clog2(STAGES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(STAGES - 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} fsm_e;

    fsm_e              state_q, state_d;
    logic [IDX_W-1:0]  stage_q;
    logic [RGBA_W-1:0] prim_q, tex1_q, tex2_q, tex3_q, prev_q, carry_q;
    logic [RGBA_W-1:0] stage_out;
    logic              upd_rgb, upd_a;

    stage_cfg_t               stage_cfg   [STAGES];
    logic [RGBA_W-1:0]        stage_const [STAGES];
    logic [CARRY_STAGES-1:0]  mask_rgb, mask_a;
    logic [RGBA_W-1:0]        buf_color;

    fcomb_cfg_regs #(
        .STAGES(STAGES), .CARRY_STAGES(CARRY_STAGES), .ADDR_W(ADDR_W), .RGBA_W(RGBA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we && state_q == S_IDLE),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .stage_cfg   (stage_cfg),
        .stage_const (stage_const),
        .mask_rgb    (mask_rgb),
        .mask_a      (mask_a),
        .buf_color   (buf_color)
    );

    fcomb_stage_alu #(.CH_W(CH_W)) u_alu (
        .cfg         (stage_cfg[stage_q]),
        .first_stage (stage_q == '0),
        .prim        (prim_q),
        .tex1        (tex1_q),
        .tex2        (tex2_q),
        .tex3        (tex3_q),
        .konst       (stage_const[stage_q]),
        .prev        (prev_q),
        .carry       (carry_q),
        .result      (stage_out)
    );

    // only stages below CARRY_STAGES own a mask bit
    always_comb begin
        upd_rgb = 1'b0;
        upd_a   = 1'b0;
        for (int i = 0; i < CARRY_STAGES; i++) begin
            if (stage_q == IDX_W'(i)) begin
                upd_rgb = mask_rgb[i];
                upd_a   = mask_a[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frag_valid) state_d = S_RUN;
            S_RUN:   if (stage_q == LAST) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            prim_q   <= '0;
            tex1_q   <= '0;
            tex2_q   <= '0;
            tex3_q   <= '0;
            prev_q   <= '0;
            carry_q  <= '0;
            pix_rgba <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (frag_valid) begin
                    stage_q <= '0;
                    prim_q  <= prim_rgba;
                    tex1_q  <= tex1_rgba;
                    tex2_q  <= tex2_rgba;
                    tex3_q  <= tex3_rgba;
                    prev_q  <= prim_rgba;
                    carry_q <= buf_color;
                end
                S_RUN: begin
                    prev_q <= stage_out;
                    if (upd_rgb) carry_q[RGB_W-1:0]      <= stage_out[RGB_W-1:0];
                    if (upd_a)   carry_q[RGBA_W-1:RGB_W] <= stage_out[RGBA_W-1:RGB_W];
                    if (stage_q == LAST) pix_rgba <= stage_out;
                    else                 stage_q  <= stage_q + 1'b1;
                end
                S_DONE: stage_q <= '0;
                default: stage_q <= '0;
            endcase
        end
    end

    always_comb begin
        frag_ready = (state_q == S_IDLE);
        pix_done   = (state_q == S_DONE);
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        pix_done |=> !pix_done);

    a_r2_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_done) |-> frag_ready);

    a_r8_late_stage_no_carry: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && stage_q >= IDX_W'(CARRY_STAGES)) |=> $stable(carry_q));

    a_r10_cfg_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> $stable(buf_color));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (frag_valid && frag_ready) |=> !frag_ready);

endmodule

// File: tb/frag_combiner_bench.sv
`timescale 1ns/1ps
module frag_combiner_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frag_valid = 1'b0;
    logic        frag_ready;
    logic [31:0] prim_rgba = '0, tex1_rgba = '0, tex2_rgba = '0, tex3_rgba = '0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pix_rgba;
    logic        pix_done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    frag_combiner u_frag_combiner (
        .clk(clk), .rst(rst), .frag_valid(frag_valid), .frag_ready(frag_ready),
        .prim_rgba(prim_rgba), .tex1_rgba(tex1_rgba), .tex2_rgba(tex2_rgba),
        .tex3_rgba(tex3_rgba), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_rgba(pix_rgba), .pix_done(pix_done)
    );

    // {primary, tex1, tex2, tex3, expected} under configuration A
    localparam logic [31:0] VEC [4][5] = '{
        '{32'h01020304, 32'h40000000, 32'h30000000, 32'hFFFFFFFF, 32'h70322314},
        '{32'hFFF0E0D0, 32'hC0000000, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFE0},
        '{32'h01020304, 32'h40000000, 32'h30000000, 32'h00000000, 32'h00000000},
        '{32'h01020304, 32'h40000000, 32'h30000000, 32'h80808080, 32'h3819120A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start(input logic [31:0] p, t1, t2, t3);
        @(negedge clk);
        frag_valid = 1'b1; prim_rgba = p; tex1_rgba = t1; tex2_rgba = t2; tex3_rgba = t3;
        @(posedge clk);
        @(negedge clk);
        frag_valid = 1'b0;
    endtask

    // called at the first falling edge after the accepting edge
    task automatic wait_done(output int lat);
        lat = 0;
        while (!pix_done && lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [31:0] p, t1, t2, t3, output logic [31:0] res, output int lat);
        start(p, t1, t2, t3);
        wait_done(lat);
        res = pix_rgba;
    endtask

    initial begin
        logic [31:0] res;
        int lat;
        int seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        check("R1 ready", {31'd0, frag_ready}, 32'd1);
        check("R1 done", {31'd0, pix_done}, 32'd0);
        check("R1 pix", pix_rgba, 32'd0);

        // configuration A (R3 R4 R7 R9 R11)
        wr(10'h0C0, 32'h000);
        wr(10'h0C8, 32'h254);
        wr(10'h0D0, 32'h00E);
        wr(10'h0D1, 32'h00302010);
        wr(10'h0D8, 32'h2FD);
        wr(10'h0F0, 32'h006);
        wr(10'h0F8, 32'h1FD);
        wr(10'h0E0, 32'h2900);

        for (int i = 0; i < 4; i++) begin
            run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], res, lat);
            check("R3 R4 R7 R9 table", res, VEC[i][4]);
            check("R2 latency", lat, 6);
        end

        // R2: busy while running, single-cycle done
        start(32'h0, 32'h0, 32'h0, 32'h0);
        check("R2 ready low in flight", {31'd0, frag_ready}, 32'd0);
        wait_done(lat);
        @(negedge clk);
        check("R2 done one cycle", {31'd0, pix_done}, 32'd0);
        check("R2 ready after done", {31'd0, frag_ready}, 32'd1);

        // R6 R11: buffer colour reaches stage 5 unchanged
        wr(10'h0E0, 32'h0);
        wr(10'h0F8, 32'h00D);
        wr(10'h0FD, 32'hA1B2C3D4);
        start(32'h0, 32'h0, 32'h0, 32'h0);
        wr(10'h0FD, 32'hDEADBEEF);   // in flight: must be dropped
        wait_done(lat);
        check("R6 carry load", pix_rgba, 32'hA1B2C3D4);
        run(32'h0, 32'h0, 32'h0, 32'h0, res, lat);
        check("R10 write in flight ignored", res, 32'hA1B2C3D4);

        // R7: alpha-only update from stage 0
        wr(10'h0FD, 32'h11223344);
        wr(10'h0C0, 32'h00E);
        wr(10'h0C1, 32'h55667788);
        wr(10'h0E0, 32'h1000);
        run(32'h0, 32'h0, 32'h0, 32'h0, res, lat);
        check("R7 alpha only", res, 32'h55223344);

        // R8: all masks set, stage 4 output must not reach carry
        wr(10'h0E0, 32'hFF00);
        wr(10'h0D8, 32'h00E);
        wr(10'h0D9, 32'h01020304);
        wr(10'h0F0, 32'h00E);
        wr(10'h0F1, 32'h99999999);
        run(32'h0, 32'h0, 32'h0, 32'h0, res, lat);
        check("R8 late stages", res, 32'h01020304);

        // R12: reset in flight
        start(32'h12345678, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (pix_done) seen++;
        end
        check("R12 no done", seen, 0);
        check("R12 ready", {31'd0, frag_ready}, 32'd1);
        check("R12 pix", pix_rgba, 32'd0);
        run(32'h0A0B0C0D, 32'hFFFFFFFF, 32'h0, 32'h0, res, lat);
        check("R1 R12 cleared config", res, 32'h0A0B0C0D);

        // R5: previous-output chain starting at stage 0
        wr(10'h0C0, 32'h00F);
        wr(10'h0C8, 32'h00F);
        wr(10'h0D0, 32'h00F);
        wr(10'h0D8, 32'h00F);
        wr(10'h0F0, 32'h00F);
        wr(10'h0F8, 32'h00F);
        run(32'h6070A0B0, 32'h0, 32'h0, 32'h0, res, lat);
        check("R5 stage0 prev", res, 32'h6070A0B0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule